// File: doc/BRIEF.md
# Flash Program/Erase Sequencer with Polled Status

This block runs the internal program and erase sequences of a seven-sector flash array. Instructions arrive already decoded, one per clock. They are a byte program, an "add sector to erase set", a whole-array erase, suspend, resume and a failure-clearing reset. Before any program or erase starts, the block looks up which sector the address falls in and checks that sector's protection bit. Program and erase time is modelled by counters. When an operation completes, the block raises a one-cycle write or erase strobe toward the array model.

While an operation runs, a read returns a status byte in place of array data. The status byte carries a polling bit, two toggle bits, an error bit and an erase-started bit. A ready output is low whenever the internal algorithm is running. An erase can be suspended, so that other sectors can be read and programmed, and then resumed from where it stopped.

The sector layout has a 16 KB boot sector, two 8 KB parameter sectors, one 32 KB sector and three 64 KB sectors over an 18-bit byte address. A parameter places the boot sector at the top or the bottom of that address space.

Top module: `pe_status_ctrl`

## Requirements
- R1: While `rst_n` is low, `rd_oe_o` is 0, `rd_data_o` is 0 and `ready_o` is 1. An operation in flight when `rst_n` falls is abandoned and writes nothing.
- R2: With `BOOT_TOP`=1, the sectors map to byte addresses as follows.
  - 0: 00000-0FFFF
  - 1: 10000-1FFFF
  - 2: 20000-2FFFF
  - 3: 30000-37FFF
  - 4: 38000-39FFF
  - 5: 3A000-3BFFF
  - 6: 3C000-3FFFF
  
  With `BOOT_TOP`=0, the layout is mirrored. Bit n of `prot_mask_i` and of `arr_ers_mask_o` refers to sector n.
- R3: A program (`cmd_op_i`=1) to an unprotected sector, accepted while idle, holds `ready_o` low for exactly `PGM_CYC` cycles. It then pulses `arr_we_o` for one cycle with the latched address and data, and a later read returns that data.
- R4: A program or an erase-add (`cmd_op_i`=2) to a sector whose `prot_mask_i` bit is set is ignored: `ready_o` stays 1 and the array is unchanged. When `unprot_i` is 1, the protection bits are overridden.
- R5: The status byte is laid out as follows.
  - bit 7: polling bit; the complement of bit 7 of the data being programmed, or 0 during an erase
  - bit 6: busy toggle (R6)
  - bit 5: error (R11)
  - bit 3: erase started (R8)
  - bit 2: erase-set toggle (R7)
  - bits 4, 1 and 0: always 0
- R6: Bit 6 inverts on every status read made while `ready_o` is 0, and holds its value on status reads while `ready_o` is 1.
- R7: Bit 2 inverts on every status read whose address lies in a sector of the current erase set. It holds its value on status reads of other sectors.
- R8: Each erase-add puts one sector into the erase set and restarts a `WIN_CYC`-cycle accept window. Bit 3 reads 0 inside the window. When the window closes, the erase begins and bit 3 reads 1.
- R9: A chip erase (`cmd_op_i`=3) erases every sector that is not protected and leaves protected sectors intact.
- R10: Suspend (`cmd_op_i`=4) during an erase raises `ready_o`. While suspended:
  - reads of sectors outside the erase set return array data;
  - reads inside the erase set return status;
  - programs outside the erase set run normally;
  - programs inside the erase set are ignored.
  
  Resume (`cmd_op_i`=5) continues the erase to completion.
- R11: If `stall_i` keeps an operation from finishing for `TMO_CYC` cycles, bit 5 becomes 1 and `ready_o` stays 0. This holds until a reset instruction (`cmd_op_i`=6) returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; also disables the read outputs |
| unprot_i | input | 1 | Temporary unprotect: overrides all protection bits |
| prot_mask_i | input | 7 | Per-sector protection bits |
| stall_i | input | 1 | Simulated non-convergence: holds the running operation from finishing |
| cmd_valid_i | input | 1 | Decoded instruction strobe |
| cmd_op_i | input | 3 | Instruction code: 1 program, 2 erase-add, 3 chip erase, 4 suspend, 5 resume, 6 reset |
| cmd_addr_i | input | 18 | Instruction byte address |
| cmd_data_i | input | 8 | Program data |
| rd_i | input | 1 | Read strobe |
| rd_addr_i | input | 18 | Read byte address |
| array_data_i | input | 8 | Array data at `rd_addr_i` |
| rd_oe_o | output | 1 | Read data enable (low models high impedance) |
| rd_data_o | output | 8 | Array data or status byte |
| ready_o | output | 1 | 1 when no internal algorithm is running |
| arr_we_o | output | 1 | One-cycle program commit strobe |
| arr_waddr_o | output | 18 | Program commit address |
| arr_wdata_o | output | 8 | Program commit data |
| arr_ers_o | output | 1 | One-cycle erase commit strobe |
| arr_ers_mask_o | output | 7 | Sectors erased by the commit |

## Verification
A stuck or wrong sequencer state shows up first on `ready_o`. The length of the low period is checked to the exact cycle for programs. A lost transition shows up as a timeout. A corrupted erase set or toggle register shows up in the status byte within two consecutive reads, through bit 2 or bit 6. A wrong sector decode shows up at the very next program, as either a rejected write to an open sector or a write that lands in a protected one. A timer that keeps its value across suspend incorrectly shows up when the resumed erase finishes, as an erase that ends too early or too late.

// File: rtl/pe_pkg.sv
`timescale 1ns/1ps
package pe_pkg;
    localparam int NBLK = 7;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_PGM      = 3'd1,
        OP_ERS_ADD  = 3'd2,
        OP_CHIP_ERS = 3'd3,
        OP_SUSP     = 3'd4,
        OP_RESUME   = 3'd5,
        OP_CLR      = 3'd6
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_WIN   = 3'd1,
        S_ERASE = 3'd2,
        S_SUSP  = 3'd3,
        S_PGM   = 3'd4,
        S_FAIL  = 3'd5
    } st_e;
endpackage

// File: rtl/pe_blk_map.sv
`timescale 1ns/1ps
module pe_blk_map #(
    parameter int ADDR_W   = 18,
    parameter bit BOOT_TOP = 1'b1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [2:0]        blk_o
);
    // top five address bits resolve the smallest (8 KB) sector
    logic [4:0] t;
    assign t = addr_i[ADDR_W-1 -: 5];

    generate
        if (BOOT_TOP) begin : g_top
            always_comb begin
                if (t[4:3] != 2'b11)      blk_o = {1'b0, t[4:3]};
                else if (t[2] == 1'b0)    blk_o = 3'd3;
                else if (t[1] == 1'b1)    blk_o = 3'd6;
                else if (t[0] == 1'b0)    blk_o = 3'd4;
                else                      blk_o = 3'd5;
            end
        end else begin : g_bot
            always_comb begin
                if (t[4:3] != 2'b00)      blk_o = 3'd3 + {1'b0, t[4:3]};
                else if (t[2] == 1'b1)    blk_o = 3'd3;
                else if (t[1] == 1'b0)    blk_o = 3'd0;
                else if (t[0] == 1'b0)    blk_o = 3'd1;
                else                      blk_o = 3'd2;
            end
        end
    endgenerate
endmodule

// File: rtl/pe_status_fmt.sv
`timescale 1ns/1ps
module pe_status_fmt #(
    parameter int DW = 8
) (
    input  logic          pgm_i,
    input  logic          data7_i,
    input  logic          tog6_i,
    input  logic          err_i,
    input  logic          started_i,
    input  logic          tog2_i,
    output logic [DW-1:0] stat_o
);
    always_comb begin
        stat_o    = '0;
        stat_o[7] = pgm_i & ~data7_i;
        stat_o[6] = tog6_i;
        stat_o[5] = err_i;
        stat_o[3] = started_i;
        stat_o[2] = tog2_i;
    end
endmodule

// File: rtl/pe_status_ctrl.sv
`timescale 1ns/1ps
module pe_status_ctrl
    import pe_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DW       = 8,
    parameter bit BOOT_TOP = 1'b1,
    parameter int PGM_CYC  = 8,
    parameter int ERS_CYC  = 40,
    parameter int WIN_CYC  = 6,
    parameter int TMO_CYC  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unprot_i,
    input  logic [6:0]        prot_mask_i,
    input  logic              stall_i,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_op_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [DW-1:0]     cmd_data_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [DW-1:0]     array_data_i,
    output logic              rd_oe_o,
    output logic [DW-1:0]     rd_data_o,
    output logic              ready_o,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_waddr_o,
    output logic [DW-1:0]     arr_wdata_o,
    output logic              arr_ers_o,
    output logic [6:0]        arr_ers_mask_o
);
    localparam int TW = $clog2(TMO_CYC + 1);
    localparam int WW = $clog2(WIN_CYC + 1);

    typedef struct packed {
        st_e               st;
        logic [TW-1:0]     etmr;
        logic [TW-1:0]     ptmr;
        logic [WW-1:0]     win;
        logic [NBLK-1:0]   mask;
        logic [NBLK-1:0]   emask;
        logic [ADDR_W-1:0] paddr;
        logic [DW-1:0]     pdata;
        logic [2:0]        pblk;
        logic              pgm;
        logic              back_susp;
        logic              started;
        logic              err;
        logic              tog6;
        logic              tog2;
        logic              we;
        logic              ers;
    } ctl_t;

    ctl_t q, d;

    logic [2:0]      cblk, rblk;
    logic [NBLK-1:0] avail;
    logic            allow_c, busy, in_set, stat_rd;
    op_e             op;
    logic [DW-1:0]   stat;

    pe_blk_map #(.ADDR_W(ADDR_W), .BOOT_TOP(BOOT_TOP)) i_cmap (.addr_i(cmd_addr_i), .blk_o(cblk));
    pe_blk_map #(.ADDR_W(ADDR_W), .BOOT_TOP(BOOT_TOP)) i_rmap (.addr_i(rd_addr_i),  .blk_o(rblk));

    pe_status_fmt #(.DW(DW)) i_fmt (
        .pgm_i(q.pgm), .data7_i(q.pdata[7]), .tog6_i(q.tog6), .err_i(q.err),
        .started_i(q.started), .tog2_i(q.tog2), .stat_o(stat)
    );

    assign op      = op_e'(cmd_op_i);
    assign avail   = ~prot_mask_i | {NBLK{unprot_i}};
    assign allow_c = avail[cblk];
    assign busy    = (q.st == S_WIN) || (q.st == S_ERASE) || (q.st == S_PGM) || (q.st == S_FAIL);
    assign in_set  = q.mask[rblk];
    assign stat_rd = rd_i && (busy || (q.st == S_SUSP && in_set));

    always_comb begin
        d     = q;
        d.we  = 1'b0;
        d.ers = 1'b0;
        if (stat_rd) begin
            if (busy)   d.tog6 = ~q.tog6;
            if (in_set) d.tog2 = ~q.tog2;
        end
        case (q.st)
            S_IDLE: if (cmd_valid_i) begin
                if (op == OP_PGM && allow_c) begin
                    d.st = S_PGM; d.ptmr = '0; d.paddr = cmd_addr_i; d.pdata = cmd_data_i;
                    d.pblk = cblk; d.pgm = 1'b1; d.back_susp = 1'b0;
                end else if (op == OP_ERS_ADD && allow_c) begin
                    d.st = S_WIN; d.win = '0; d.mask = NBLK'(1) << cblk;
                end else if (op == OP_CHIP_ERS && avail != '0) begin
                    d.st = S_ERASE; d.etmr = '0; d.mask = avail; d.started = 1'b1;
                end
            end
            S_WIN: begin
                if (cmd_valid_i && op == OP_ERS_ADD && allow_c) begin
                    d.mask = q.mask | (NBLK'(1) << cblk);
                    d.win  = '0;
                end else if (q.win == WW'(WIN_CYC - 1)) begin
                    d.st = S_ERASE; d.etmr = '0; d.started = 1'b1;
                end else begin
                    d.win = q.win + 1'b1;
                end
            end
            S_ERASE: begin
                if (cmd_valid_i && op == OP_SUSP) begin
                    d.st = S_SUSP;
                end else if (!stall_i && q.etmr == TW'(ERS_CYC - 1)) begin
                    d.ers = 1'b1; d.emask = q.mask; d.mask = '0;
                    d.started = 1'b0; d.st = S_IDLE;
                end else if (q.etmr == TW'(TMO_CYC - 1)) begin
                    d.st = S_FAIL; d.err = 1'b1;
                end else begin
                    d.etmr = q.etmr + 1'b1;
                end
            end
            S_SUSP: if (cmd_valid_i) begin
                if (op == OP_RESUME) begin
                    d.st = S_ERASE;
                end else if (op == OP_PGM && allow_c && !q.mask[cblk]) begin
                    d.st = S_PGM; d.ptmr = '0; d.paddr = cmd_addr_i; d.pdata = cmd_data_i;
                    d.pblk = cblk; d.pgm = 1'b1; d.back_susp = 1'b1;
                end
            end
            S_PGM: begin
                if (!stall_i && q.ptmr == TW'(PGM_CYC - 1)) begin
                    d.we = 1'b1; d.pgm = 1'b0;
                    d.st = q.back_susp ? S_SUSP : S_IDLE;
                end else if (q.ptmr == TW'(TMO_CYC - 1)) begin
                    d.st = S_FAIL; d.err = 1'b1;
                end else begin
                    d.ptmr = q.ptmr + 1'b1;
                end
            end
            S_FAIL: if (cmd_valid_i && op == OP_CLR) d = '0;
            default: d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ready_o        = !busy;
    assign rd_oe_o        = rst_n && rd_i;
    assign rd_data_o      = !rd_oe_o ? '0 : (stat_rd ? stat : array_data_i);
    assign arr_we_o       = q.we;
    assign arr_waddr_o    = q.paddr;
    assign arr_wdata_o    = q.pdata;
    assign arr_ers_o      = q.ers;
    assign arr_ers_mask_o = q.emask;

    // R4: a program to a locked sector while idle leaves the block ready
    a_r4_locked_pgm_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && op == OP_PGM && q.st == S_IDLE && !allow_c) |=> ready_o);

    // R10: no program commit ever lands in a sector of the pending erase set
    a_r10_no_write_in_set: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> !q.mask[q.pblk]);

    // R11: a failed operation holds until the clearing instruction
    a_r11_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_FAIL && !(cmd_valid_i && op == OP_CLR)) |=> (!ready_o && q.err));

    // R3: the commit strobe is a single cycle
    a_r3_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |=> !arr_we_o);

    // R9: an erase commit always names at least one sector
    a_r9_ers_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        arr_ers_o |-> (arr_ers_mask_o != '0));
endmodule

// File: tb/test_pe_status_ctrl.sv
`timescale 1ns/1ps
module test_pe_status_ctrl;
    localparam int PGM = 8;
    localparam int ERS = 40;
    localparam int WIN = 6;
    localparam int TMO = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        unprot = 1'b0;
    logic [6:0]  prot = 7'b0010010;
    logic        stall = 1'b0;
    logic        cv = 1'b0;
    logic [2:0]  cop = '0;
    logic [17:0] caddr = '0;
    logic [7:0]  cdata = '0;
    logic        rd = 1'b0;
    logic [17:0] raddr = '0;
    logic [7:0]  adata;
    logic        rd_oe, ready, we, ers;
    logic [7:0]  rdata, wdata;
    logic [17:0] waddr;
    logic [6:0]  emask;

    int n_vec = 0;
    int n_err = 0;
    logic [7:0] mem [0:111];

    always #2.5 clk = ~clk;

    pe_status_ctrl #(.PGM_CYC(PGM), .ERS_CYC(ERS), .WIN_CYC(WIN), .TMO_CYC(TMO)) i_pe_status_ctrl (
        .clk(clk), .rst_n(rst_n), .unprot_i(unprot), .prot_mask_i(prot), .stall_i(stall),
        .cmd_valid_i(cv), .cmd_op_i(cop), .cmd_addr_i(caddr), .cmd_data_i(cdata),
        .rd_i(rd), .rd_addr_i(raddr), .array_data_i(adata), .rd_oe_o(rd_oe),
        .rd_data_o(rdata), .ready_o(ready), .arr_we_o(we), .arr_waddr_o(waddr),
        .arr_wdata_o(wdata), .arr_ers_o(ers), .arr_ers_mask_o(emask)
    );

    // sector map with the boot sector at the top (R2)
    function automatic int sect(logic [17:0] a);
        if (a < 18'h10000) return 0;
        if (a < 18'h20000) return 1;
        if (a < 18'h30000) return 2;
        if (a < 18'h38000) return 3;
        if (a < 18'h3A000) return 4;
        if (a < 18'h3C000) return 5;
        return 6;
    endfunction

    function automatic int slot(logic [17:0] a);
        return sect(a) * 16 + int'(a[3:0]);
    endfunction

    initial for (int i = 0; i < 112; i++) mem[i] = 8'hFF;

    always_comb adata = mem[slot(raddr)];

    always @(posedge clk) begin
        if (we) mem[slot(waddr)] <= mem[slot(waddr)] & wdata;
        if (ers) for (int b = 0; b < 7; b++)
            if (emask[b]) for (int k = 0; k < 16; k++) mem[b*16+k] <= 8'hFF;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cmd(input int o, input logic [17:0] a, input logic [7:0] dd);
        @(negedge clk);
        cv = 1'b1; cop = 3'(o); caddr = a; cdata = dd;
        @(negedge clk);
        cv = 1'b0;
    endtask

    task automatic rdo(input logic [17:0] a, output logic [7:0] v);
        rd = 1'b1; raddr = a;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wait_ready(input int lim, output int n);
        n = 0;
        while (!ready && n < lim) begin
            n++;
            @(negedge clk);
        end
    endtask

    // {address, data, accepted}; sectors 1 and 4 are locked
    localparam logic [26:0] VEC [0:7] = '{
        {18'h0FFFF, 8'hA5, 1'b1},
        {18'h10000, 8'h12, 1'b0},
        {18'h37FFF, 8'h3C, 1'b1},
        {18'h38000, 8'h00, 1'b0},
        {18'h39FFF, 8'h0F, 1'b0},
        {18'h3A000, 8'h81, 1'b1},
        {18'h3C000, 8'h7E, 1'b1},
        {18'h3FFFF, 8'h5A, 1'b1}
    };

    initial begin
        repeat (1000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        int n;
        logic [7:0] v1, v2;

        // R1: outputs disabled and ready while reset is held
        rd = 1'b1; raddr = 18'h00000;
        repeat (2) @(negedge clk);
        chk(rd_oe == 1'b0, "R1 oe", int'(rd_oe), 0);
        chk(rdata == 8'h00, "R1 data", int'(rdata), 0);
        chk(ready == 1'b1, "R1 ready", int'(ready), 1);
        rd = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4: vector walk across sector boundaries
        for (int i = 0; i < 8; i++) begin
            cmd(1, VEC[i][26:9], VEC[i][8:1]);
            wait_ready(200, n);
            @(negedge clk);
            rdo(VEC[i][26:9], v1);
            if (VEC[i][0]) begin
                chk(n == PGM, "R3 busy cycles", n, PGM);
                chk(v1 == VEC[i][8:1], "R2 readback", int'(v1), int'(VEC[i][8:1]));
            end else begin
                chk(n == 0, "R4 locked stays ready", n, 0);
                chk(v1 == 8'hFF, "R4 locked unchanged", int'(v1), 'hFF);
            end
        end

        // R5 R6 R7: status while programming
        cmd(1, 18'h00003, 8'h5A);
        rdo(18'h00003, v1);
        rdo(18'h20000, v2);
        chk(v1[7] == 1'b1, "R5 polling bit", int'(v1[7]), 1);
        chk((v1 & 8'h3B) == 8'h00, "R5 fixed bits", int'(v1 & 8'h3B), 0);
        chk(v1[6] != v2[6], "R6 busy toggle", int'(v2[6]), int'(~v1[6]));
        chk(v1[2] == v2[2], "R7 no set toggle", int'(v2[2]), int'(v1[2]));
        wait_ready(200, n);
        @(negedge clk);

        // R4: unprotect override
        unprot = 1'b1;
        cmd(1, 18'h10004, 8'h3C);
        wait_ready(200, n);
        unprot = 1'b0;
        @(negedge clk);
        rdo(18'h10004, v1);
        chk(v1 == 8'h3C, "R4 unprotect", int'(v1), 'h3C);

        // R8: multi-sector erase window
        cmd(2, 18'h00003, 8'h00);
        cmd(2, 18'h10000, 8'h00);
        rdo(18'h00003, v1);
        chk(v1[3] == 1'b0, "R8 window bit3", int'(v1[3]), 0);
        chk(ready == 1'b0, "R8 busy in window", int'(ready), 0);
        cmd(2, 18'h3A000, 8'h00);
        repeat (WIN + 2) @(negedge clk);
        rdo(18'h3A000, v1);
        rdo(18'h3A000, v2);
        chk(v1[3] == 1'b1, "R8 started bit3", int'(v1[3]), 1);
        chk(v1[7] == 1'b0, "R5 erase polling", int'(v1[7]), 0);
        chk(v1[2] != v2[2], "R7 set toggle", int'(v2[2]), int'(~v1[2]));
        rdo(18'h30000, v1);
        rdo(18'h30000, v2);
        chk(v1[2] == v2[2], "R7 outside set steady", int'(v2[2]), int'(v1[2]));

        // R10: suspend
        cmd(4, 18'h0, 8'h0);
        chk(ready == 1'b1, "R10 suspend ready", int'(ready), 1);
        rdo(18'h37FFF, v1);
        chk(v1 == 8'h3C, "R10 array outside set", int'(v1), 'h3C);
        rdo(18'h3A001, v1);
        rdo(18'h3A001, v2);
        chk(v1[6] == v2[6], "R6 steady when ready", int'(v2[6]), int'(v1[6]));
        chk(v1[2] != v2[2], "R7 suspended set toggle", int'(v2[2]), int'(~v1[2]));
        cmd(1, 18'h00003, 8'h00);
        chk(ready == 1'b1, "R10 program in set ignored", int'(ready), 1);
        cmd(1, 18'h30001, 8'h77);
        wait_ready(200, n);
        chk(n == PGM, "R10 program while suspended", n, PGM);
        @(negedge clk);
        chk(ready == 1'b1, "R10 back to suspended", int'(ready), 1);
        cmd(5, 18'h0, 8'h0);
        chk(ready == 1'b0, "R10 resume busy", int'(ready), 0);
        wait_ready(200, n);
        @(negedge clk);
        rdo(18'h00003, v1);
        chk(v1 == 8'hFF, "R10 sector0 erased", int'(v1), 'hFF);
        rdo(18'h3A000, v1);
        chk(v1 == 8'hFF, "R10 sector5 erased", int'(v1), 'hFF);
        rdo(18'h30001, v1);
        chk(v1 == 8'h77, "R10 suspended program kept", int'(v1), 'h77);
        rdo(18'h10004, v1);
        chk(v1 == 8'h3C, "R4 locked sector not erased", int'(v1), 'h3C);

        // R11: timeout and clear
        stall = 1'b1;
        cmd(1, 18'h00005, 8'h11);
        repeat (TMO + 4) @(negedge clk);
        rdo(18'h00005, v1);
        chk(v1[5] == 1'b1, "R11 error bit", int'(v1[5]), 1);
        chk(ready == 1'b0, "R11 stays busy", int'(ready), 0);
        cmd(6, 18'h0, 8'h0);
        chk(ready == 1'b1, "R11 cleared", int'(ready), 1);
        stall = 1'b0;
        rdo(18'h00005, v1);
        chk(v1 == 8'hFF, "R11 no write", int'(v1), 'hFF);

        // R9: chip erase spares locked sectors
        cmd(3, 18'h0, 8'h0);
        wait_ready(200, n);
        @(negedge clk);
        rdo(18'h30001, v1);
        chk(v1 == 8'hFF, "R9 open sector erased", int'(v1), 'hFF);
        rdo(18'h3FFFF, v1);
        chk(v1 == 8'hFF, "R9 boot erased", int'(v1), 'hFF);
        rdo(18'h10004, v1);
        chk(v1 == 8'h3C, "R9 locked kept", int'(v1), 'h3C);

        // R1: reset mid-program abandons it
        cmd(1, 18'h0000A, 8'h00);
        @(negedge clk);
        rst_n = 1'b0;
        rd = 1'b1;
        #1;
        chk(rd_oe == 1'b0, "R1 oe mid-op", int'(rd_oe), 0);
        chk(ready == 1'b1, "R1 ready mid-op", int'(ready), 1);
        @(negedge clk);
        rd = 1'b0; rst_n = 1'b1;
        repeat (PGM + 2) @(negedge clk);
        rdo(18'h0000A, v1);
        chk(v1 == 8'hFF, "R1 abandoned write", int'(v1), 'hFF);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule